// File: doc/BRIEF.md
# RTC Prescaler and Periodic Rate Generator

This block sits between a 32.768 kHz oscillator and a real-time clock's time-keeping counters. It runs a 15-stage binary prescaler, advanced by a clock-enable that marks each oscillator cycle. When the chain wraps it issues a once-per-second update tick. The same chain also feeds a periodic event whose period is chosen by a 4-bit rate code. A status bit warns software, well ahead of each update, that the time registers are about to change.

A control byte sets the prescaler mode and the rate code. Its 3-bit mode field selects normal counting, holding the chain in reset, stopping it, or one of three test modes that skip the first 5, 10 or 15 stages. The byte is written and read through a simple single-cycle port. It has no reset, so it keeps its contents across a system reset. The periodic event comes out as a one-cycle flag, and also as an interrupt that is gated by an enable input.

Top module: `rtc_divider`

## Requirements
- R1: The control byte reads as bit 7 = update-in-progress status, bits 6:4 = mode field, bits 3:0 = rate code. A write stores bits 6:0 on the clock edge where the write strobe is high, and the written bit 7 has no effect.
- R2: Asserting the asynchronous reset leaves the stored mode field and rate code unchanged.
- R3: With mode 010 (normal), the update tick is a one-cycle pulse that repeats every 32768 advances. An advance is a clock cycle with the oscillator enable high.
- R4: Modes 110 and 111 hold the chain at its midpoint and give neither ticks nor periodic flags. After a switch to mode 010, the first tick follows exactly 16384 advances.
- R5: Modes 000 and 001 freeze the chain and give neither ticks nor periodic flags.
- R6: Modes 011, 100 and 101 produce a tick every 1024, 32 and 1 advances respectively.
- R7: Rate codes 0011 to 1111 give a periodic flag every 2^(code-1) advances, from 4 up to 16384. The flags stay aligned to the chain, so in normal mode a flag falls on the tick cycle.
- R8: Rate code 0001 gives a period of 128 advances and code 0010 a period of 256 advances.
- R9: Rate code 0000 produces no periodic flag.
- R10: The periodic interrupt pulses with the flag when the interrupt enable is high, and stays low when it is low.
- R11: In normal mode, the status bit rises 17 advances before the tick, which is more than 492 us. It stays high on the tick cycle and falls 8 advances after the tick.
- R12: Cycles with the oscillator enable low never advance the chain and never produce a tick or flag.
- R13: While reset is asserted, the tick, flag and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | One-cycle enable per 32.768 kHz oscillator period |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read data with status in bit 7 |
| per_irq_en | input | 1 | Periodic interrupt enable |
| per_flag | output | 1 | One-cycle periodic event flag |
| per_irq | output | 1 | Periodic interrupt, flag gated by enable |
| upd_tick | output | 1 | One-cycle update tick at chain wrap |

## Verification
The periodic flag and the update tick come from the same carry, so they can land in the same cycle. The status window also reloads on that same cycle. The bench provokes the overlap by leaving hold mode with rate 0011, and again later with rate 1111. In both cases the final flag of the count must coincide with the tick, and the status bit must already be high there. Each period and lead time is judged as an exact count of advances, worked out from powers of two in the bench.

// File: rtl/rtc_divider_pkg.sv
package rtc_divider_pkg;

  typedef enum logic [2:0] {
    CH_STOP,
    CH_RUN,
    CH_SKIP1,
    CH_SKIP2,
    CH_SKIP3,
    CH_HOLD
  } chain_mode_e;

  // rate codes that alias onto slower taps (low-bit widths)
  localparam logic [3:0] ALIAS1_WIDTH = 4'd7;
  localparam logic [3:0] ALIAS2_WIDTH = 4'd8;

  function automatic chain_mode_e decode_mode(input logic [2:0] fld);
    chain_mode_e m;
    case (fld)
      3'b010:         m = CH_RUN;
      3'b011:         m = CH_SKIP1;
      3'b100:         m = CH_SKIP2;
      3'b101:         m = CH_SKIP3;
      3'b110, 3'b111: m = CH_HOLD;
      default:        m = CH_STOP;
    endcase
    return m;
  endfunction

  // number of low chain bits that must be zero for a periodic event; 0 = off
  function automatic logic [3:0] tap_width(input logic [3:0] code);
    logic [3:0] w;
    case (code)
      4'd0:    w = 4'd0;
      4'd1:    w = ALIAS1_WIDTH;
      4'd2:    w = ALIAS2_WIDTH;
      default: w = code - 4'd1;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/rtc_ctrl_reg.sv
module rtc_ctrl_reg (
  input  logic       clk,
  input  logic       we,
  input  logic [6:0] wdata,
  output logic [2:0] mode_fld,
  output logic [3:0] rate_code
);

  logic [6:0] ctl_q;
  logic [6:0] ctl_d;

  // no reset: contents survive system reset
  always_comb begin
    ctl_d = ctl_q;
    if (we) ctl_d = wdata;
  end

  always_ff @(posedge clk) begin
    ctl_q <= ctl_d;
  end

  assign mode_fld  = ctl_q[6:4];
  assign rate_code = ctl_q[3:0];

endmodule

// File: rtl/rtc_div_chain.sv
module rtc_div_chain
  import rtc_divider_pkg::*;
#(
  parameter int STAGES   = 15,
  parameter int SKIP_STP = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  chain_mode_e       mode,
  output logic [STAGES-1:0] cnt,
  output logic [STAGES-1:0] cnt_nxt,
  output logic              adv,
  output logic              carry
);

  localparam int SUM_W = STAGES + 1;
  localparam logic [STAGES-1:0] MID = STAGES'(1) << (STAGES - 1);

  logic [STAGES-1:0] cnt_q;
  logic [STAGES-1:0] cnt_d;
  logic [SUM_W-1:0]  step;
  logic [SUM_W-1:0]  sum;

  // skipping k stages equals adding 2^k per oscillator cycle
  always_comb begin
    case (mode)
      CH_RUN:   step = SUM_W'(1);
      CH_SKIP1: step = SUM_W'(1) << SKIP_STP;
      CH_SKIP2: step = SUM_W'(1) << (2 * SKIP_STP);
      CH_SKIP3: step = SUM_W'(1) << (3 * SKIP_STP);
      default:  step = '0;
    endcase
  end

  assign sum   = {1'b0, cnt_q} + step;
  assign adv   = osc_en && (step != '0);
  assign carry = adv && sum[STAGES];

  always_comb begin
    cnt_d = cnt_q;
    if (mode == CH_HOLD) cnt_d = MID;
    else if (adv)        cnt_d = sum[STAGES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt     = cnt_q;
  assign cnt_nxt = sum[STAGES-1:0];

endmodule

// File: rtl/rtc_rate_tap.sv
module rtc_rate_tap
  import rtc_divider_pkg::*;
#(
  parameter int STAGES = 15
) (
  input  logic [3:0]        rate_code,
  input  logic              adv,
  input  logic [STAGES-1:0] cnt_nxt,
  output logic              fire
);

  logic [3:0]        width;
  logic [STAGES-1:0] mask;

  assign width = tap_width(rate_code);
  assign mask  = (STAGES'(1) << width) - STAGES'(1);
  assign fire  = adv && (width != 4'd0) && ((cnt_nxt & mask) == '0);

endmodule

// File: rtl/rtc_uip_gen.sv
module rtc_uip_gen
  import rtc_divider_pkg::*;
#(
  parameter int STAGES = 15,
  parameter int LEAD   = 17,
  parameter int WIN    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en,
  input  chain_mode_e       mode,
  input  logic [STAGES-1:0] cnt,
  input  logic              carry,
  output logic              uip
);

  localparam int WIN_W = $clog2(WIN + 1);
  localparam logic [STAGES-1:0] LEAD_AT = STAGES'((1 << STAGES) - LEAD);

  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] win_d;

  always_comb begin
    win_d = win_q;
    if (mode == CH_HOLD)
      win_d = '0;
    else if (carry)
      win_d = WIN_W'(WIN);
    else if (osc_en && (mode != CH_STOP) && (win_q != '0))
      win_d = win_q - WIN_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end

  assign uip = ((mode == CH_RUN) && (cnt >= LEAD_AT)) || (win_q != '0);

endmodule

// File: rtl/rtc_divider.sv
module rtc_divider
  import rtc_divider_pkg::*;
#(
  parameter int STAGES   = 15,
  parameter int SKIP_STP = 5,
  parameter int UIP_LEAD = 17,
  parameter int UPD_WIN  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       per_irq_en,
  output logic       per_flag,
  output logic       per_irq,
  output logic       upd_tick
);

  logic [2:0]        mode_fld;
  logic [3:0]        rate_code;
  chain_mode_e       mode;
  logic [STAGES-1:0] cnt;
  logic [STAGES-1:0] cnt_nxt;
  logic              adv;
  logic              carry;
  logic              fire;
  logic              uip;
  logic              tick_q, tick_d;
  logic              flag_q, flag_d;
  logic              wr_status_unused;

  assign wr_status_unused = ctl_wdata[7];

  rtc_ctrl_reg u_ctl (
    .clk       (clk),
    .we        (ctl_we),
    .wdata     (ctl_wdata[6:0]),
    .mode_fld  (mode_fld),
    .rate_code (rate_code)
  );

  assign mode = decode_mode(mode_fld);

  rtc_div_chain #(.STAGES(STAGES), .SKIP_STP(SKIP_STP)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .osc_en  (osc_en),
    .mode    (mode),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt),
    .adv     (adv),
    .carry   (carry)
  );

  rtc_rate_tap #(.STAGES(STAGES)) u_tap (
    .rate_code (rate_code),
    .adv       (adv),
    .cnt_nxt   (cnt_nxt),
    .fire      (fire)
  );

  rtc_uip_gen #(.STAGES(STAGES), .LEAD(UIP_LEAD), .WIN(UPD_WIN)) u_uip (
    .clk    (clk),
    .rst_n  (rst_n),
    .osc_en (osc_en),
    .mode   (mode),
    .cnt    (cnt),
    .carry  (carry),
    .uip    (uip)
  );

  always_comb begin
    tick_d = carry;
    flag_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      tick_q <= tick_d;
      flag_q <= flag_d;
    end
  end

  assign upd_tick  = tick_q;
  assign per_flag  = flag_q;
  assign per_irq   = flag_q & per_irq_en;
  assign ctl_rdata = {uip, mode_fld, rate_code};

endmodule

// File: rtl/rtc_divider_chk.sv
module rtc_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_en,
  input logic [7:0] ctl_rdata,
  input logic       per_irq_en,
  input logic       per_flag,
  input logic       per_irq,
  input logic       upd_tick
);

  a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && ctl_rdata[6:4] == 3'b010) |=> !upd_tick);

  a_r4_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[6:5] == 2'b11) |=> (!upd_tick && !per_flag));

  a_r5_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[6:5] == 2'b00) |=> (!upd_tick && !per_flag));

  a_r9_rate_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[3:0] == 4'd0) |=> !per_flag);

  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    per_irq |-> (per_irq_en && per_flag));

  a_r11_uip_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_tick && ctl_rdata[6:4] == 3'b010 && $past(ctl_rdata[6:4]) == 3'b010)
      |-> $past(ctl_rdata[7]));

  a_r11_uip_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
    upd_tick |-> ctl_rdata[7]);

  a_r12_idle_osc: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> (!upd_tick && !per_flag));

endmodule

bind rtc_divider rtc_divider_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .osc_en     (osc_en),
  .ctl_rdata  (ctl_rdata),
  .per_irq_en (per_irq_en),
  .per_flag   (per_flag),
  .per_irq    (per_irq),
  .upd_tick   (upd_tick)
);

// File: tb/tb_rtc_divider.sv
module tb_rtc_divider;

  logic       clk;
  logic       rst_n;
  logic       osc_en;
  logic       ctl_we;
  logic [7:0] ctl_wdata;
  logic [7:0] ctl_rdata;
  logic       per_irq_en;
  logic       per_flag;
  logic       per_irq;
  logic       upd_tick;

  int n_chk;
  int n_fail;
  bit done;

  rtc_divider dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .osc_en     (osc_en),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .ctl_rdata  (ctl_rdata),
    .per_irq_en (per_irq_en),
    .per_flag   (per_flag),
    .per_irq    (per_irq),
    .upd_tick   (upd_tick)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] b);
    ctl_we    = 1'b1;
    ctl_wdata = b;
    step();
    ctl_we    = 1'b0;
  endtask

  // count ticks and flags over n cycles
  task automatic quiet(input int n, output int ticks, output int flags);
    ticks = 0;
    flags = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (upd_tick) ticks++;
      if (per_flag) flags++;
    end
  endtask

  task automatic flag_period(input logic [3:0] code, output int per, output int irq_seen);
    wr({1'b0, 3'b010, code});
    per_irq_en = code[0];
    per = -1;
    irq_seen = 0;
    for (int i = 0; i < 40000; i++) begin
      step();
      if (per_flag) break;
    end
    for (int i = 1; i < 40000; i++) begin
      step();
      if (per_flag) begin
        per = i;
        irq_seen = int'(per_irq);
        break;
      end
    end
  endtask

  task automatic tick_period(input logic [2:0] fld, output int per);
    wr({1'b0, fld, 4'd0});
    per = -1;
    if (!upd_tick) begin
      for (int i = 0; i < 40000; i++) begin
        step();
        if (upd_tick) break;
      end
    end
    for (int i = 1; i < 40000; i++) begin
      step();
      if (upd_tick) begin
        per = i;
        break;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int t, f, per, irqs, fl_cnt, first_uip, tick_i, fl_at_tick, uip_at_tick, fall_i, rise_i, irq_cnt;
    n_chk = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    osc_en = 1'b1;
    ctl_we = 1'b0;
    ctl_wdata = 8'h00;
    per_irq_en = 1'b0;
    @(negedge clk);
    step();
    step();
    // R13: outputs low under reset
    chk(!upd_tick && !per_flag && !per_irq, "R13 outputs in reset", int'({upd_tick, per_flag, per_irq}), 0);

    // R1/R2: write during reset, then reset again
    wr(8'h25);
    rst_n = 1'b1;
    step();
    chk(ctl_rdata[6:0] == 7'h25, "R1 readback", int'(ctl_rdata[6:0]), 'h25);
    rst_n = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    step();
    chk(ctl_rdata[6:0] == 7'h25, "R2 persists across reset", int'(ctl_rdata[6:0]), 'h25);
    // R1: written status bit ignored
    wr(8'hA0);
    chk(ctl_rdata == 8'h20, "R1 status bit not writable", int'(ctl_rdata), 'h20);

    // R4: hold mode is quiet
    wr(8'h63);
    quiet(60, t, f);
    chk(t == 0 && f == 0, "R4 hold quiet", t + f, 0);

    // leave hold: first tick after 16384 advances, rate 3 aligned
    wr(8'h23);
    fl_cnt = 0; first_uip = -1; tick_i = -1; fl_at_tick = 0; uip_at_tick = 0; irq_cnt = 0;
    for (int i = 1; i <= 17000; i++) begin
      step();
      if (per_flag) fl_cnt++;
      if (per_irq) irq_cnt++;
      if (ctl_rdata[7] && first_uip < 0) first_uip = i;
      if (upd_tick) begin
        tick_i = i;
        fl_at_tick = int'(per_flag);
        uip_at_tick = int'(ctl_rdata[7]);
        break;
      end
    end
    chk(tick_i == 16384, "R4 first tick after hold", tick_i, 16384);
    chk(fl_cnt == 4096, "R7 code3 flags in half second", fl_cnt, 4096);
    chk(fl_at_tick == 1, "R7 flag coincides with tick", fl_at_tick, 1);
    chk(irq_cnt == 0, "R10 irq masked", irq_cnt, 0);
    chk(first_uip == 16367, "R11 status lead", first_uip, 16367);
    chk(uip_at_tick == 1, "R11 status on tick", uip_at_tick, 1);

    // full second in normal mode, rate 15, irq enabled
    per_irq_en = 1'b1;
    wr(8'h2F);
    chk(!upd_tick, "R3 tick one cycle", int'(upd_tick), 0);
    fl_cnt = int'(per_flag); irq_cnt = int'(per_irq);
    fall_i = ctl_rdata[7] ? -1 : 1; rise_i = -1; tick_i = -1;
    for (int i = 2; i <= 33000; i++) begin
      step();
      if (per_flag) fl_cnt++;
      if (per_irq) irq_cnt++;
      if (!ctl_rdata[7] && fall_i < 0) fall_i = i;
      if (ctl_rdata[7] && fall_i > 0 && rise_i < 0) rise_i = i;
      if (upd_tick) begin
        tick_i = i;
        break;
      end
    end
    chk(fall_i == 8, "R11 status falls after window", fall_i, 8);
    chk(rise_i == 32751, "R11 status rises before second tick", rise_i, 32751);
    chk(tick_i == 32768, "R3 one tick per 32768 advances", tick_i, 32768);
    chk(fl_cnt == 2, "R7 code15 flags per second", fl_cnt, 2);
    chk(irq_cnt == 2, "R10 irq follows flag", irq_cnt, 2);

    // R7/R8 sweep of all rate codes, R10 with enable toggling per code
    for (int c = 1; c < 16; c++) begin
      int exp_p;
      exp_p = (c == 1) ? 128 : (c == 2) ? 256 : (1 << (c - 1));
      flag_period(4'(c), per, irqs);
      if (c <= 2) chk(per == exp_p, "R8 alias period", per, exp_p);
      else        chk(per == exp_p, "R7 rate period", per, exp_p);
      chk(irqs == (c % 2), "R10 irq gating", irqs, c % 2);
    end

    // R9: code 0 off
    wr(8'h20);
    quiet(3000, t, f);
    chk(f == 0, "R9 rate off", f, 0);

    // R6: test modes
    tick_period(3'b011, per);
    chk(per == 1024, "R6 skip5 period", per, 1024);
    tick_period(3'b100, per);
    chk(per == 32, "R6 skip10 period", per, 32);
    tick_period(3'b101, per);
    chk(per == 1, "R6 skip15 period", per, 1);

    // R12: oscillator enable gating in skip15 mode
    t = 0;
    for (int i = 0; i < 20; i++) begin
      osc_en = (i % 2 == 0);
      step();
      if (upd_tick) t++;
    end
    chk(t == 10, "R12 half-rate enable", t, 10);
    osc_en = 1'b0;
    quiet(20, t, f);
    chk(t == 0 && f == 0, "R12 enable low", t + f, 0);
    osc_en = 1'b1;

    // R5: invalid modes
    wr(8'h03);
    quiet(200, t, f);
    chk(t == 0 && f == 0, "R5 mode 000 stopped", t + f, 0);
    wr(8'h13);
    quiet(200, t, f);
    chk(t == 0 && f == 0, "R5 mode 001 stopped", t + f, 0);

    // R4: mode 111 also holds
    wr(8'h73);
    quiet(200, t, f);
    chk(t == 0 && f == 0, "R4 mode 111 hold", t + f, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule